// File: doc/BRIEF.md
# Register-Configured Video Test Pattern Generator

The block produces a synthetic video stream for bringing up and checking a display path. A pair of horizontal and vertical counters runs the standard raster (active area, front porch, sync pulse, back porch) and the block drives 8-bit red, green and blue pixel values together with horizontal sync, vertical sync and blanking. The default timing is 1024x768 active pixels for a 65 MHz pixel clock: a 1344-cycle line and an 806-line frame with negative sync pulses. Every timing value is a parameter.

Software programs the picture through a small Wishbone slave. It chooses one of four shapes: horizontal bands, vertical bands, a checkerboard, or a flat fill. It also sets a rectangular window where the shape is drawn, the band or square size, a base colour, and a colour step that is added from one band to the next. Writes land in a staging copy, and a commit write marks that copy as complete. The raster engine pulses a frame request in the last cycle of every frame. At that pulse it copies the staging set into the live set, but only if the staging set is committed. A frame is therefore always drawn from a single consistent set of settings.

The design is a single clock domain. Bus, counters and pixel output share `clk`.

Top module: `test_pattern_gen`

## Requirements
- R1: With line total HT = H_ACTIVE+H_FRONT+H_SYNC+H_BACK and frame total VT built the same way, the outputs for counter position (h,v) appear one clock after that position. `blank_o` is 1 unless h < H_ACTIVE and v < V_ACTIVE. `hsync_o` is 0 exactly for H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC, and 1 otherwise. `vsync_o` follows the same rule on v with the vertical values. Both syncs are 1 during reset.
- R2: `frame_req_o` is 1 for exactly one cycle per frame, while the counters stand at (HT-1, VT-1). The next cycle is position (0,0).
- R3: Pattern code 0 (horizontal bands): an enabled pixel inside the window gets colour base + n*step, where n = (y - y_lo) / size. The arithmetic is done per channel.
- R4: Pattern code 1 (vertical bands): as R3, with n = (x - x_lo) / size.
- R5: Pattern code 2 (checkerboard): the colour is base when ((x-x_lo)/size + (y-y_lo)/size) is even, and base+step when it is odd. Pattern code 3 is a flat fill of base.
- R6: A pixel is drawn only when the enable bit is 1 and x_lo <= x < x_hi and y_lo <= y < y_hi. Every other pixel, and every blanked pixel, is 0 on all three channels.
- R7: Each 8-bit channel wraps modulo 256 on its own. No carry passes between channels.
- R8: Register map, one 32-bit word each (word address on `wb_adr_i`):
  - 0: bits[1:0] pattern code, bit 2 enable.
  - 1: x_lo in [15:0], x_hi in [31:16].
  - 2: y_lo in [15:0], y_hi in [31:16].
  - 3: size in [15:0].
  - 4: base colour as R[23:16] G[15:8] B[7:0].
  - 5: step, in the same layout as the base colour.
  - 6: commit. A read returns the committed flag in bit 0.
  - 7: a write has no effect and a read returns 0.
  
  Reads return the staged values with unused bits 0. `wb_ack_o` rises one clock after a strobe and lasts one cycle. Every register resets to 0.
- R9: `cfg_valid_o` is 1 after reset. A write to addresses 0 to 5 clears it from the next cycle. A write to address 6 sets it.
- R10: The staged settings are copied into the live settings only at the `frame_req_o` cycle, and only if `cfg_valid_o` is 1 in that cycle. Otherwise the next frame is drawn with the previous live settings.
- R11: A size of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 = write |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Transfer acknowledge |
| cfg_valid_o | output | 1 | Staged settings committed |
| frame_req_o | output | 1 | New-frame request pulse |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | 1 outside the active area |

## Verification
The bench runs each shape code over full frames, comparing every pixel against a closed-form quotient model.
- The horizontal and vertical band runs tell apart a mix-up of the x and y axes.
- The checkerboard run shows whether the two parities are combined correctly.
- A window that sits off the edges, together with a step that overflows each channel, checks window clipping and per-channel wrap.
- A size of zero and a flat fill exercise the degenerate cases.
- An uncommitted write followed by a full frame separates frame-boundary loading from immediate loading.
- Random settings written at random points in the frame check that changes take effect only at the boundary.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int CH_W   = 8;
  localparam int N_CH   = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int FLD_W  = 16;

  typedef enum logic [1:0] {
    PAT_ROWS  = 2'd0,
    PAT_COLS  = 2'd1,
    PAT_CHECK = 2'd2,
    PAT_SOLID = 2'd3
  } pat_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_WINX = 3'd1;
  localparam logic [ADDR_W-1:0] A_WINY = 3'd2;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
  localparam logic [ADDR_W-1:0] A_BASE = 3'd4;
  localparam logic [ADDR_W-1:0] A_STEP = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMIT = 3'd6;

  typedef logic [N_CH-1:0][CH_W-1:0] rgb_t;

  typedef struct packed {
    logic             en;
    pat_e             kind;
    logic [FLD_W-1:0] x_lo;
    logic [FLD_W-1:0] x_hi;
    logic [FLD_W-1:0] y_lo;
    logic [FLD_W-1:0] y_hi;
    logic [FLD_W-1:0] size;
    rgb_t             base;
    rgb_t             step;
  } cfg_t;

  localparam cfg_t CFG_RESET = '0;
endpackage

// File: rtl/tpg_wb_regs.sv
module tpg_wb_regs
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  output cfg_t              stg_o,
  output logic              valid_o
);
  logic req;
  assign req = cyc_i && stb_i && !ack_o;

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    case (adr_i)
      A_CTRL:  rd_word = {29'd0, stg_o.en, stg_o.kind};
      A_WINX:  rd_word = {stg_o.x_hi, stg_o.x_lo};
      A_WINY:  rd_word = {stg_o.y_hi, stg_o.y_lo};
      A_SIZE:  rd_word = {16'd0, stg_o.size};
      A_BASE:  rd_word = {8'd0, stg_o.base};
      A_STEP:  rd_word = {8'd0, stg_o.step};
      A_CMIT:  rd_word = {31'd0, valid_o};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o   <= 1'b0;
      dat_o   <= '0;
      stg_o   <= CFG_RESET;
      valid_o <= 1'b1;
    end else begin
      ack_o <= req;
      if (req && !we_i) dat_o <= rd_word;
      if (req && we_i) begin
        case (adr_i)
          A_CTRL: begin
            stg_o.kind <= pat_e'(dat_i[1:0]);
            stg_o.en   <= dat_i[2];
            valid_o    <= 1'b0;
          end
          A_WINX: begin
            stg_o.x_lo <= dat_i[15:0];
            stg_o.x_hi <= dat_i[31:16];
            valid_o    <= 1'b0;
          end
          A_WINY: begin
            stg_o.y_lo <= dat_i[15:0];
            stg_o.y_hi <= dat_i[31:16];
            valid_o    <= 1'b0;
          end
          A_SIZE: begin
            stg_o.size <= dat_i[15:0];
            valid_o    <= 1'b0;
          end
          A_BASE: begin
            stg_o.base <= dat_i[23:0];
            valid_o    <= 1'b0;
          end
          A_STEP: begin
            stg_o.step <= dat_i[23:0];
            valid_o    <= 1'b0;
          end
          A_CMIT:  valid_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_ack_single_r8: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  p_ack_follows_r8: assert property (@(posedge clk) disable iff (rst)
    req |=> ack_o);
  p_stage_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (req && we_i && (adr_i < A_CMIT)) |=> !valid_o);
  p_commit_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (req && we_i && (adr_i == A_CMIT)) |=> valid_o);
endmodule

// File: rtl/tpg_timing.sv
module tpg_timing #(
  parameter int H_ACT = 1024,
  parameter int H_FP  = 24,
  parameter int H_SW  = 136,
  parameter int H_BP  = 160,
  parameter int V_ACT = 768,
  parameter int V_FP  = 3,
  parameter int V_SW  = 6,
  parameter int V_BP  = 29,
  parameter int HCW   = 11,
  parameter int VCW   = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hcnt_o,
  output logic [VCW-1:0] vcnt_o,
  output logic           de_o,
  output logic           hs_act_o,
  output logic           vs_act_o,
  output logic           frame_req_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam logic [HCW-1:0] H_LAST = HCW'(H_TOT - 1);
  localparam logic [VCW-1:0] V_LAST = VCW'(V_TOT - 1);
  localparam logic [HCW-1:0] H_VIS  = HCW'(H_ACT);
  localparam logic [VCW-1:0] V_VIS  = VCW'(V_ACT);
  localparam logic [HCW-1:0] HS_BEG = HCW'(H_ACT + H_FP);
  localparam logic [HCW-1:0] HS_END = HCW'(H_ACT + H_FP + H_SW);
  localparam logic [VCW-1:0] VS_BEG = VCW'(V_ACT + V_FP);
  localparam logic [VCW-1:0] VS_END = VCW'(V_ACT + V_FP + V_SW);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else if (hcnt_o == H_LAST) begin
      hcnt_o <= '0;
      vcnt_o <= (vcnt_o == V_LAST) ? '0 : vcnt_o + 1'b1;
    end else begin
      hcnt_o <= hcnt_o + 1'b1;
    end
  end

  assign de_o        = (hcnt_o < H_VIS) && (vcnt_o < V_VIS);
  assign hs_act_o    = (hcnt_o >= HS_BEG) && (hcnt_o < HS_END);
  assign vs_act_o    = (vcnt_o >= VS_BEG) && (vcnt_o < VS_END);
  assign frame_req_o = (hcnt_o == H_LAST) && (vcnt_o == V_LAST);

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hcnt_o == H_LAST) |=> (hcnt_o == '0));
  p_row_step_r1: assert property (@(posedge clk) disable iff (rst)
    (hcnt_o == H_LAST && vcnt_o != V_LAST) |=> (vcnt_o == $past(vcnt_o) + 1'b1));
  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    frame_req_o |=> !frame_req_o);
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    frame_req_o |=> (hcnt_o == '0 && vcnt_o == '0));
endmodule

// File: rtl/tpg_axis_track.sv
module tpg_axis_track
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [FLD_W-1:0] size,
  input  rgb_t             base,
  input  rgb_t             step,
  output rgb_t             color_o,
  output logic             parity_o
);
  logic [FLD_W-1:0] cnt;
  logic [FLD_W-1:0] limit;
  rgb_t             off;
  rgb_t             off_nx;

  assign limit = (size == '0) ? '0 : size - 1'b1;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign off_nx[ch]  = off[ch] + step[ch];
    assign color_o[ch] = base[ch] + off[ch];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt      <= '0;
      off      <= '0;
      parity_o <= 1'b0;
    end else if (advance) begin
      if (cnt >= limit) begin
        cnt      <= '0;
        off      <= off_nx;
        parity_o <= ~parity_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt <= limit));
  p_clear_origin_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0 && off == '0 && !parity_o));
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
  import tpg_pkg::*;
#(
  parameter int H_ACT    = 1024,
  parameter int V_ACT    = 768,
  parameter int HCW      = 11,
  parameter int VCW      = 10,
  parameter bit SYNC_NEG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  input  logic           de,
  input  logic           hs_act,
  input  logic           vs_act,
  input  logic           frame_req,
  input  cfg_t           stg_cfg,
  input  logic           stg_valid,
  output rgb_t           rgb_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           blank_o
);
  localparam logic [HCW-1:0] H_VIS = HCW'(H_ACT);
  localparam logic [VCW-1:0] V_VIS = VCW'(V_ACT);
  localparam logic [HCW-1:0] H_END = HCW'(H_ACT - 1);

  cfg_t act;
  always_ff @(posedge clk) begin
    if (rst) act <= CFG_RESET;
    else if (frame_req && stg_valid) act <= stg_cfg;
  end

  logic [FLD_W-1:0] x16, y16;
  logic in_x, in_y;
  assign x16  = FLD_W'(hcnt);
  assign y16  = FLD_W'(vcnt);
  assign in_x = (hcnt < H_VIS) && (x16 >= act.x_lo) && (x16 < act.x_hi);
  assign in_y = (vcnt < V_VIS) && (y16 >= act.y_lo) && (y16 < act.y_hi);

  rgb_t col_c, row_c, alt_c;
  logic col_par, row_par;

  tpg_axis_track u_col (
    .clk(clk), .rst(rst), .clear(!in_x), .advance(in_x),
    .size(act.size), .base(act.base), .step(act.step),
    .color_o(col_c), .parity_o(col_par)
  );

  tpg_axis_track u_row (
    .clk(clk), .rst(rst), .clear(!in_y), .advance(in_y && (hcnt == H_END)),
    .size(act.size), .base(act.base), .step(act.step),
    .color_o(row_c), .parity_o(row_par)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_alt
    assign alt_c[ch] = act.base[ch] + act.step[ch];
  end

  rgb_t pix;
  always_comb begin
    case (act.kind)
      PAT_ROWS:  pix = row_c;
      PAT_COLS:  pix = col_c;
      PAT_CHECK: pix = (row_par ^ col_par) ? alt_c : act.base;
      default:   pix = act.base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_o   <= '0;
      hsync_o <= SYNC_NEG;
      vsync_o <= SYNC_NEG;
      blank_o <= 1'b1;
    end else begin
      rgb_o   <= (de && act.en && in_x && in_y) ? pix : '0;
      hsync_o <= hs_act ^ SYNC_NEG;
      vsync_o <= vs_act ^ SYNC_NEG;
      blank_o <= !de;
    end
  end

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_req |=> $stable(act));
  p_no_load_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_req && !stg_valid) |=> $stable(act));
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_req && stg_valid) |=> (act == $past(stg_cfg)));
  p_blank_black_r6: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> (rgb_o == '0));
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int H_ACTIVE = 1024,
  parameter int H_FRONT  = 24,
  parameter int H_SYNC   = 136,
  parameter int H_BACK   = 160,
  parameter int V_ACTIVE = 768,
  parameter int V_FRONT  = 3,
  parameter int V_SYNC   = 6,
  parameter int V_BACK   = 29,
  parameter bit SYNC_NEG = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic        cfg_valid_o,
  output logic        frame_req_o,
  output logic [7:0]  red_o,
  output logic [7:0]  green_o,
  output logic [7:0]  blue_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        blank_o
);
  localparam int H_TOT = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOT = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = $clog2(V_TOT);

  cfg_t           stg;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           de, hs_act, vs_act;
  rgb_t           rgb;

  tpg_wb_regs u_regs (
    .clk(clk), .rst(rst), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i), .dat_o(wb_dat_o), .ack_o(wb_ack_o),
    .stg_o(stg), .valid_o(cfg_valid_o)
  );

  tpg_timing #(
    .H_ACT(H_ACTIVE), .H_FP(H_FRONT), .H_SW(H_SYNC), .H_BP(H_BACK),
    .V_ACT(V_ACTIVE), .V_FP(V_FRONT), .V_SW(V_SYNC), .V_BP(V_BACK),
    .HCW(HCW), .VCW(VCW)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt_o(hcnt), .vcnt_o(vcnt), .de_o(de),
    .hs_act_o(hs_act), .vs_act_o(vs_act), .frame_req_o(frame_req_o)
  );

  tpg_pattern #(
    .H_ACT(H_ACTIVE), .V_ACT(V_ACTIVE), .HCW(HCW), .VCW(VCW), .SYNC_NEG(SYNC_NEG)
  ) u_pattern (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .de(de), .hs_act(hs_act),
    .vs_act(vs_act), .frame_req(frame_req_o), .stg_cfg(stg), .stg_valid(cfg_valid_o),
    .rgb_o(rgb), .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
  );

  assign red_o   = rgb[2];
  assign green_o = rgb[1];
  assign blue_o  = rgb[0];
endmodule

// File: tb/test_pattern_gen_bench.sv
module test_pattern_gen_bench;
  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [2:0]  adr = '0;
  logic [31:0] dat = '0;
  logic [31:0] rdat;
  logic ack, cval, freq, hs, vs, bl;
  logic [7:0] r, g, b;

  always #10 clk = ~clk;

  test_pattern_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) u_test_pattern_gen (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .cfg_valid_o(cval), .frame_req_o(freq), .red_o(r), .green_o(g), .blue_o(b),
    .hsync_o(hs), .vsync_o(vs), .blank_o(bl)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // bench model of the register state
  logic [31:0] m_stg [6];
  logic [31:0] m_act [6];
  bit m_valid;
  int hc, vc;
  bit started = 0;
  logic [23:0] e_rgb;
  logic e_hs, e_vs, e_bl;
  string e_tag;

  function automatic logic [23:0] model_rgb(input int x, input int y);
    int xlo, xhi, ylo, yhi, w, xi, yi, n;
    logic [23:0] res;
    if (!m_act[0][2]) return 24'd0;
    xlo = int'(m_act[1][15:0]); xhi = int'(m_act[1][31:16]);
    ylo = int'(m_act[2][15:0]); yhi = int'(m_act[2][31:16]);
    w = int'(m_act[3][15:0]);
    if (w == 0) w = 1;
    if (x < xlo || x >= xhi || y < ylo || y >= yhi) return 24'd0;
    xi = (x - xlo) / w;
    yi = (y - ylo) / w;
    case (m_act[0][1:0])
      2'd0: n = yi;
      2'd1: n = xi;
      2'd2: n = (xi + yi) % 2;
      default: n = 0;
    endcase
    for (int ch = 0; ch < 3; ch++)
      res[ch*8 +: 8] = 8'((int'(m_act[4][ch*8 +: 8]) + n * int'(m_act[5][ch*8 +: 8])) % 256);
    return res;
  endfunction

  function automatic logic [31:0] mask_word(input int a, input logic [31:0] d);
    case (a)
      0: return d & 32'h7;
      3: return d & 32'hFFFF;
      4, 5: return d & 32'hFF_FFFF;
      default: return d;
    endcase
  endfunction

  task automatic calc_exp();
    bit vis;
    vis = (hc < HA) && (vc < VA);
    e_bl = !vis;
    e_hs = !((hc >= HA + HF) && (hc < HA + HF + HS));
    e_vs = !((vc >= VA + VF) && (vc < VA + VF + VS));
    e_rgb = vis ? model_rgb(hc, vc) : 24'd0;
    case (m_act[0][1:0])
      2'd0: e_tag = "R3 R6 R7 R10 R11";
      2'd1: e_tag = "R4 R6 R7 R10 R11";
      default: e_tag = "R5 R6 R7 R10";
    endcase
  endtask

  always @(negedge clk) begin
    if (rst) begin
      started = 0;
    end else begin
      if (!started) begin
        started = 1;
        hc = 0; vc = 0; m_valid = 1;
        for (int i = 0; i < 6; i++) begin m_stg[i] = '0; m_act[i] = '0; end
        calc_exp();
      end
      // outputs reflect the previous cycle's position
      chk({"pixel ", e_tag}, {r, g, b}, e_rgb);
      chk("R1 hsync", hs, e_hs);
      chk("R1 vsync", vs, e_vs);
      chk("R1 blank", bl, e_bl);
      if (hc == HT - 1 && vc == VT - 1 && m_valid)
        for (int i = 0; i < 6; i++) m_act[i] = m_stg[i];
      if (hc == HT - 1) begin
        hc = 0;
        vc = (vc == VT - 1) ? 0 : vc + 1;
      end else hc++;
      chk("R2 frame_req", freq, (hc == HT - 1 && vc == VT - 1));
      if (ack && we && cyc) begin
        if (adr < 3'd6) begin
          m_stg[adr] = mask_word(int'(adr), dat);
          m_valid = 0;
        end else if (adr == 3'd6) m_valid = 1;
      end
      chk("R9 cfg_valid", cval, m_valid);
      calc_exp();
    end
  end

  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    cyc = 1; stb = 1; we = 1; adr = a; dat = d;
    do @(negedge clk); while (!ack);
    #1 cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    cyc = 1; stb = 1; we = 0; adr = a;
    do @(negedge clk); while (!ack);
    d = rdat;
    #1 cyc = 0; stb = 0;
  endtask

  task automatic setup(input logic [31:0] c, wx, wy, sz, bs, st);
    wb_write(3'd0, c);  wb_write(3'd1, wx); wb_write(3'd2, wy);
    wb_write(3'd3, sz); wb_write(3'd4, bs); wb_write(3'd5, st);
    wb_write(3'd6, 32'd1);
  endtask

  task automatic frames(input int n);
    repeat (n * HT * VT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd20417));
    repeat (4) @(negedge clk);
    chk("R1 reset rgb", {r, g, b}, 24'd0);
    chk("R1 reset blank", bl, 1'b1);
    chk("R1 reset hsync", hs, 1'b1);
    chk("R1 reset vsync", vs, 1'b1);
    chk("R8 reset ack", ack, 1'b0);
    chk("R9 reset valid", cval, 1'b1);
    #1 rst = 0;

    for (int a = 0; a < 6; a++) begin
      wb_read(3'(a), rv);
      chk("R8 reset readback", rv, 32'd0);
    end
    wb_read(3'd6, rv);
    chk("R9 commit flag after reset", rv, 32'd1);

    // R3: horizontal bands, full window
    setup(32'h4, {16'd16, 16'd0}, {16'd12, 16'd0}, 32'd3, 32'h102030, 32'h080402);
    wb_read(3'd1, rv); chk("R8 readback x window", rv, {16'd16, 16'd0});
    wb_read(3'd4, rv); chk("R8 readback base", rv, 32'h102030);
    wb_read(3'd7, rv); chk("R8 unused address reads 0", rv, 32'd0);
    frames(2);

    // R4 + R7: vertical bands, clipped window, wrapping step
    setup(32'h5, {16'd14, 16'd2}, {16'd10, 16'd1}, 32'd4, 32'hF0F8FC, 32'h701008);
    frames(2);

    // R5: checkerboard
    setup(32'h6, {16'd13, 16'd3}, {16'd9, 16'd2}, 32'd2, 32'h112233, 32'h445566);
    frames(2);

    // R11: zero size as one
    setup(32'h4, {16'd16, 16'd0}, {16'd12, 16'd0}, 32'd0, 32'h000000, 32'h0A141E);
    wb_read(3'd3, rv); chk("R11 size reads back 0", rv, 32'd0);
    frames(2);

    // R5 flat fill; R6 windows past the raster edge
    setup(32'h7, {16'd40, 16'd5}, {16'd30, 16'd6}, 32'd1, 32'hABCDEF, 32'h010101);
    frames(2);

    // R6: disabled
    setup(32'h3, {16'd16, 16'd0}, {16'd12, 16'd0}, 32'd1, 32'hFFFFFF, 32'h0);
    frames(2);

    // R10: staged but not committed
    setup(32'h6, {16'd16, 16'd0}, {16'd12, 16'd0}, 32'd3, 32'h203040, 32'h102030);
    frames(2);
    wb_write(3'd0, 32'h5);
    wb_read(3'd6, rv); chk("R9 flag low while staging", rv, 32'd0);
    frames(2);
    wb_write(3'd6, 32'd1);
    wb_read(3'd6, rv); chk("R9 flag high after commit", rv, 32'd1);
    frames(2);

    // random settings at random points in the frame
    for (int it = 0; it < 14; it++) begin
      logic [31:0] wv [6];
      wv[0] = $urandom % 8;
      wv[1] = {16'($urandom % (HA + 3)), 16'($urandom % (HA + 2))};
      wv[2] = {16'($urandom % (VA + 3)), 16'($urandom % (VA + 2))};
      wv[3] = $urandom % 6;
      wv[4] = $urandom;
      wv[5] = $urandom;
      for (int a = 0; a < 6; a++) begin
        repeat ($urandom % 40) @(negedge clk);
        wb_write(3'(a), wv[a]);
      end
      wb_read(3'd3, rv); chk("R8 random size readback", rv, wv[3] & 32'hFFFF);
      if ($urandom % 4 != 0) wb_write(3'd6, 32'd1);
      repeat (HT * VT + ($urandom % 300)) @(negedge clk);
    end
    wb_write(3'd6, 32'd1);
    frames(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule